// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a serial audio stream from an external source that owns the bit clock and the word clock, and turns it into parallel samples in the local system clock domain. The bit clock, word clock and data line pass through a two-flop synchronizer. The receiver then finds bit-clock rising edges in the system clock, which must run at least four times faster than the bit clock. On each of those edges it takes one data bit and one word-clock level.

The framing family is chosen by configuration inputs. The choices are the two-channel families (I2S, left-justified and right-justified) and a time-division multiplexed (TDM) family with four or eight slots. In TDM the word clock is either a 50% duty clock or a one-bit pulse. Either clock can be inverted. Samples are two's complement and arrive most significant bit first. Each one leaves as a 24-bit word with a channel or slot index and a one-cycle valid strobe. Configuration inputs are expected to change only while reset is held.

A four-state machine does the work. IDLE waits for a channel or frame start. DELAY counts off the data delay. CAPTURE shifts bits in. DRAIN waits once a word is complete. The transitions are as follows:
- start (any state to DELAY, or to CAPTURE when the delay is zero): a channel edge or frame start arrives.
- delay_done (DELAY to CAPTURE): the delay count runs out.
- word_full (CAPTURE to DRAIN): the 24th bit is captured.
- slot_next (CAPTURE or DRAIN to CAPTURE): in TDM, a slot boundary is reached.
- slots_done (CAPTURE or DRAIN to IDLE): in TDM, the last configured slot ends.

Top module: `serial_audio_rx`

## Requirements
- R1: In I2S (cfg_fmt 2'b00) a low word clock is the left channel (chan_o 0) and a high one is the right channel (chan_o 1). The MSB is the bit one bit clock after the word clock edge. Left is emitted before right, and the 24 received bits appear unchanged on sample_o.
- R2: In left-justified (cfg_fmt 2'b01) a high word clock is the left channel, and the MSB is the bit sampled with the word clock edge.
- R3: A word longer than 24 bits yields its top 24 bits, emitted as soon as the 24th bit arrives, and the rest are dropped without any error. A shorter word is placed in the upper bits with zeros below it and is emitted when its channel ends.
- R4: In right-justified (cfg_fmt 2'b10) a high word clock is the left channel. The data begins 8 bit clocks after the edge when cfg_rj16 is 0, which gives a 24-bit word. It begins 16 bit clocks after the edge when cfg_rj16 is 1, which gives a 16-bit word in the upper bits.
- R5: In TDM (cfg_fmt 2'b11) with a clock-style word clock, a frame starts on its falling edge and the rising edge in mid-frame has no effect. Slot k has its MSB 1 + 32k bit clocks after the frame start, and is emitted with chan_o = k.
- R6: With cfg_lr_pulse 1 in TDM, a frame starts on the rising edge of a one-bit-wide word-clock pulse, and its falling edge has no effect.
- R7: cfg_tdm8 1 gives eight slots. cfg_tdm8 0 gives four, and any slots beyond the fourth in a frame produce no output.
- R8: cfg_lr_inv 1 inverts the word clock before any decoding.
- R9: Bits are sampled on the rising bit-clock edge. With cfg_bclk_inv 1 they are sampled on the falling edge instead.
- R10: In reset valid_o and sample_o are 0. After reset, no word is emitted before the first channel or frame start, whatever the data line carries.
- R11: valid_o is high for exactly one system clock per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | External bit clock |
| lrclk_i | input | 1 | External word clock |
| sdata_i | input | 1 | Serial data |
| cfg_fmt | input | 2 | 00 I2S, 01 left-justified, 10 right-justified, 11 TDM |
| cfg_bclk_inv | input | 1 | Sample on the falling bit-clock edge |
| cfg_lr_inv | input | 1 | Invert the word clock |
| cfg_lr_pulse | input | 1 | TDM word clock is a one-bit pulse |
| cfg_rj16 | input | 1 | Right-justified: 16-bit word with delay 16 (else 24-bit with delay 8) |
| cfg_tdm8 | input | 1 | TDM with eight slots (else four) |
| sample_o | output | 24 | Received sample, MSB-aligned |
| chan_o | output | 3 | Channel (0 left, 1 right) or TDM slot |
| valid_o | output | 1 | One-cycle strobe for sample_o and chan_o |

## Verification
The bench drives stretched channels of 40 bits carrying 32-bit words. A design that failed to stop at 24 bits would emit the low bits or lose the word. It also drives short 20-bit channels carrying 16-bit words. A design that did not flush at the channel edge would never emit those words or would leave them unshifted. In TDM the mid-frame word-clock edge and the falling edge of the pulse are both present in the stimulus, so a design that treated either as a frame start would restart slot 0 and produce extra words. The bench also sends a four-slot configuration over an eight-slot frame, where any output from slots 4 to 7 is caught as unexpected. Data ones ahead of the first edge would expose a design that captures while idle, and the inverted-clock runs show a polarity handled at the wrong point as corrupted words.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_TDM = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DELAY,
        ST_CAPTURE,
        ST_DRAIN
    } rx_state_e;
endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic lrclk_i,
    input  logic sdata_i,
    input  logic bclk_inv,
    output logic bit_stb,
    output logic lr_bit,
    output logic d_bit
);
    logic [STAGES-1:0] b_sh, l_sh, d_sh;
    logic              b_last;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_sh   <= '0;
            l_sh   <= '0;
            d_sh   <= '0;
            b_last <= 1'b0;
        end else begin
            b_sh   <= {b_sh[STAGES-2:0], bclk_i ^ bclk_inv};
            l_sh   <= {l_sh[STAGES-2:0], lrclk_i};
            d_sh   <= {d_sh[STAGES-2:0], sdata_i};
            b_last <= b_sh[STAGES-1];
        end
    end

    assign bit_stb = b_sh[STAGES-1] & ~b_last;
    assign lr_bit  = l_sh[STAGES-1];
    assign d_bit   = d_sh[STAGES-1];

    AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb); // R9
endmodule

// File: rtl/sarx_frame.sv
module sarx_frame
    import sarx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_stb,
    input  logic lr_bit,
    input  fmt_e fmt,
    input  logic lr_inv,
    input  logic lr_pulse,
    output logic start,
    output logic left
);
    logic lr_prev, primed, lvl, chg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lr_prev <= 1'b0;
            primed  <= 1'b0;
        end else if (bit_stb) begin
            lr_prev <= lvl;
            primed  <= 1'b1;
        end
    end

    always_comb begin
        lvl   = lr_bit ^ lr_inv;
        chg   = primed && (lvl != lr_prev);
        left  = (fmt == FMT_I2S) ? !lvl : lvl;
        if (fmt == FMT_TDM)
            start = bit_stb && chg && (lr_pulse ? lvl : !lvl);
        else
            start = bit_stb && chg;
    end
endmodule

// File: rtl/sarx_deser.sv
module sarx_deser
    import sarx_pkg::*;
#(
    parameter int WORD_W       = 24,
    parameter int SLOT_W       = 32,
    parameter int MAX_SLOTS    = 8,
    parameter int RJ_SHORT_DLY = 8,
    parameter int RJ_LONG_DLY  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bit_stb,
    input  logic                          d_bit,
    input  logic                          start,
    input  logic                          left,
    input  fmt_e                          fmt,
    input  logic                          rj16,
    input  logic                          tdm8,
    output logic [WORD_W-1:0]             sample_o,
    output logic [$clog2(MAX_SLOTS)-1:0]  chan_o,
    output logic                          valid_o
);
    localparam int SIW   = $clog2(MAX_SLOTS);
    localparam int SIW1  = SIW + 1;
    localparam int CNT_W = $clog2(SLOT_W);
    localparam int NB_W  = $clog2(WORD_W + 1);
    localparam int DLY_W = $clog2(RJ_LONG_DLY + 1);

    rx_state_e         state_q, state_n;
    logic [DLY_W-1:0]  dly_q, dly_n, dval;
    logic [CNT_W-1:0]  sbit_q, sbit_n;
    logic [SIW-1:0]    slot_q, slot_n;
    logic [WORD_W-1:0] sh_q, sh_n, emit_word;
    logic [NB_W-1:0]   nb_q, nb_n;
    logic [SIW1-1:0]   nslots;
    logic              is_tdm, emit;
    logic [SIW-1:0]    emit_chan;

    always_comb begin
        is_tdm = (fmt == FMT_TDM);
        nslots = tdm8 ? SIW1'(MAX_SLOTS) : SIW1'(MAX_SLOTS / 2);
        unique case (fmt)
            FMT_LJ:  dval = '0;
            FMT_RJ:  dval = rj16 ? DLY_W'(RJ_LONG_DLY) : DLY_W'(RJ_SHORT_DLY);
            default: dval = DLY_W'(1);
        endcase
    end

    // next-state and datapath
    always_comb begin
        state_n   = state_q;
        dly_n     = dly_q;
        sbit_n    = sbit_q;
        slot_n    = slot_q;
        sh_n      = sh_q;
        nb_n      = nb_q;
        emit      = 1'b0;
        emit_word = sh_q << (NB_W'(WORD_W) - nb_q);
        emit_chan = slot_q;
        if (bit_stb) begin
            if (start) begin
                emit   = (state_q == ST_CAPTURE);
                slot_n = (is_tdm || left) ? '0 : SIW'(1);
                sbit_n = '0;
                if (dval == '0) begin
                    sh_n    = {sh_q[WORD_W-2:0], d_bit};
                    nb_n    = NB_W'(1);
                    state_n = ST_CAPTURE;
                end else begin
                    dly_n   = dval - 1'b1;
                    state_n = ST_DELAY;
                end
            end else begin
                unique case (state_q)
                    ST_IDLE: ;
                    ST_DELAY: begin
                        if (dly_q == '0) begin
                            sh_n    = {sh_q[WORD_W-2:0], d_bit};
                            nb_n    = NB_W'(1);
                            sbit_n  = '0;
                            state_n = ST_CAPTURE;
                        end else begin
                            dly_n = dly_q - 1'b1;
                        end
                    end
                    ST_CAPTURE, ST_DRAIN: begin
                        if (is_tdm && sbit_q == CNT_W'(SLOT_W - 1)) begin
                            emit = (state_q == ST_CAPTURE);
                            if ({1'b0, slot_q} + 1'b1 >= nslots) begin
                                state_n = ST_IDLE;
                            end else begin
                                slot_n  = slot_q + 1'b1;
                                sbit_n  = '0;
                                sh_n    = {sh_q[WORD_W-2:0], d_bit};
                                nb_n    = NB_W'(1);
                                state_n = ST_CAPTURE;
                            end
                        end else begin
                            sbit_n = sbit_q + 1'b1;
                            if (state_q == ST_CAPTURE) begin
                                sh_n = {sh_q[WORD_W-2:0], d_bit};
                                nb_n = nb_q + 1'b1;
                                if (nb_q + 1'b1 == NB_W'(WORD_W)) begin
                                    emit      = 1'b1;
                                    emit_word = {sh_q[WORD_W-2:0], d_bit};
                                    state_n   = ST_DRAIN;
                                end
                            end
                        end
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dly_q   <= '0;
            sbit_q  <= '0;
            slot_q  <= '0;
            sh_q    <= '0;
            nb_q    <= '0;
        end else begin
            state_q <= state_n;
            dly_q   <= dly_n;
            sbit_q  <= sbit_n;
            slot_q  <= slot_n;
            sh_q    <= sh_n;
            nb_q    <= nb_n;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o  <= 1'b0;
            sample_o <= '0;
            chan_o   <= '0;
        end else begin
            valid_o <= emit;
            if (emit) begin
                sample_o <= emit_word;
                chan_o   <= emit_chan;
            end
        end
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R11
    AST_PAIR_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !is_tdm) |-> (chan_o < SIW'(2))); // R1
    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && is_tdm) |-> ({1'b0, chan_o} < nslots)); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !(bit_stb && start)) |=> !valid_o); // R10
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int WORD_W      = 24,
    parameter int SLOT_W      = 32,
    parameter int MAX_SLOTS   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bclk_i,
    input  logic                         lrclk_i,
    input  logic                         sdata_i,
    input  logic [1:0]                   cfg_fmt,
    input  logic                         cfg_bclk_inv,
    input  logic                         cfg_lr_inv,
    input  logic                         cfg_lr_pulse,
    input  logic                         cfg_rj16,
    input  logic                         cfg_tdm8,
    output logic [WORD_W-1:0]            sample_o,
    output logic [$clog2(MAX_SLOTS)-1:0] chan_o,
    output logic                         valid_o
);
    logic bit_stb, lr_bit, d_bit, start, left;
    fmt_e fmt;

    assign fmt = fmt_e'(cfg_fmt);

    sarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .sdata_i(sdata_i), .bclk_inv(cfg_bclk_inv),
        .bit_stb(bit_stb), .lr_bit(lr_bit), .d_bit(d_bit)
    );

    sarx_frame u_frame (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .lr_bit(lr_bit),
        .fmt(fmt), .lr_inv(cfg_lr_inv), .lr_pulse(cfg_lr_pulse),
        .start(start), .left(left)
    );

    sarx_deser #(.WORD_W(WORD_W), .SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS)) u_deser (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .d_bit(d_bit),
        .start(start), .left(left), .fmt(fmt), .rj16(cfg_rj16),
        .tdm8(cfg_tdm8), .sample_o(sample_o), .chan_o(chan_o),
        .valid_o(valid_o)
    );
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0, lrclk_i = 1'b0, sdata_i = 1'b0;
    logic [1:0]  cfg_fmt = 2'b00;
    logic        cfg_bclk_inv = 1'b0, cfg_lr_inv = 1'b0, cfg_lr_pulse = 1'b0;
    logic        cfg_rj16 = 1'b0, cfg_tdm8 = 1'b1;
    logic [23:0] sample_o;
    logic [2:0]  chan_o;
    logic        valid_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";
    logic [26:0] exp_q[$];
    string       req_q[$];
    logic        prev_valid = 1'b0;
    int          b2b = 0;
    logic [31:0] tw [8];

    always #10 clk = ~clk;

    serial_audio_rx i_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .lrclk_i(lrclk_i),
        .sdata_i(sdata_i), .cfg_fmt(cfg_fmt), .cfg_bclk_inv(cfg_bclk_inv),
        .cfg_lr_inv(cfg_lr_inv), .cfg_lr_pulse(cfg_lr_pulse),
        .cfg_rj16(cfg_rj16), .cfg_tdm8(cfg_tdm8), .sample_o(sample_o),
        .chan_o(chan_o), .valid_o(valid_o)
    );

    function automatic logic [23:0] fit24(input logic [31:0] w, input int wlen);
        logic [31:0] t;
        if (wlen >= 24) t = w >> (wlen - 24);
        else            t = w << (24 - wlen);
        return t[23:0];
    endfunction

    task automatic push(input logic [2:0] ch, input logic [23:0] d, input string r);
        exp_q.push_back({ch, d});
        req_q.push_back(r);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid_o && prev_valid) b2b++;
            if (valid_o) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL %s: unexpected word chan=%0d data=%h, expected none",
                             cur_req, chan_o, sample_o);
                end else begin
                    logic [26:0] e;
                    string r;
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    checks++;
                    if ({chan_o, sample_o} !== e) begin
                        errors++;
                        $display("FAIL %s: chan=%0d data=%h, expected chan=%0d data=%h",
                                 r, chan_o, sample_o, e[26:24], e[23:0]);
                    end
                end
            end
        end
        prev_valid = valid_o;
    end

    task automatic bit_out(input logic lvl, input logic d);
        @(negedge clk);
        bclk_i  = cfg_bclk_inv;
        lrclk_i = lvl ^ cfg_lr_inv;
        sdata_i = d;
        repeat (4) @(negedge clk);
        bclk_i = ~cfg_bclk_inv;
        repeat (3) @(negedge clk);
    endtask

    task automatic setup(input logic [1:0] f, input logic binv, input logic linv,
                         input logic pulse, input logic r16, input logic t8, input string r);
        @(negedge clk);
        rst_n = 1'b0;
        cur_req = r;
        cfg_fmt = f; cfg_bclk_inv = binv; cfg_lr_inv = linv;
        cfg_lr_pulse = pulse; cfg_rj16 = r16; cfg_tdm8 = t8;
        bclk_i = binv;
        sdata_i = 1'b0;
        exp_q.delete(); req_q.delete();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic drained(input string r);
        repeat (20) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d words missing, expected 0 missing", r, exp_q.size());
            exp_q.delete(); req_q.delete();
        end
    endtask

    task automatic run_2ch(input int nch, input int wlen, input logic [31:0] wl,
                           input logic [31:0] wr, input string r);
        int dly;
        logic leftlvl;
        leftlvl = (cfg_fmt == 2'b00) ? 1'b0 : 1'b1;
        if (cfg_fmt == 2'b01) dly = 0;
        else if (cfg_fmt == 2'b10) dly = cfg_rj16 ? 16 : 8;
        else dly = 1;
        push(3'd0, fit24(wl, wlen), r);
        push(3'd1, fit24(wr, wlen), r);
        for (int i = 0; i < 4; i++) bit_out(~leftlvl, 1'b1);   // ignored before first edge
        for (int ch = 0; ch < 2; ch++) begin
            for (int p = 0; p < nch; p++) begin
                logic [31:0] w;
                logic d;
                w = (ch == 0) ? wl : wr;
                d = (p >= dly && p - dly < wlen) ? w[wlen - 1 - (p - dly)] : 1'b0;
                bit_out((ch == 0) ? leftlvl : ~leftlvl, d);
            end
        end
        bit_out(leftlvl, 1'b0);
        bit_out(leftlvl, 1'b0);
        drained(r);
    endtask

    task automatic run_tdm(input int wlen, input string r);
        int nsl;
        nsl = cfg_tdm8 ? 8 : 4;
        for (int k = 0; k < nsl; k++) push(3'(k), fit24(tw[k], wlen), r);
        for (int i = 0; i < 4; i++) bit_out(~cfg_lr_pulse, 1'b1);
        for (int p = 0; p < 256; p++) begin
            logic lvl, d;
            int q;
            q = p - 1;
            lvl = cfg_lr_pulse ? (p == 0) : (p >= 128);
            d = (p >= 1 && (q % 32) < wlen) ? tw[q / 32][wlen - 1 - (q % 32)] : 1'b0;
            bit_out(lvl, d);
        end
        if (cfg_lr_pulse) bit_out(1'b1, 1'b0);
        else              bit_out(1'b0, 1'b0);
        bit_out(1'b0, 1'b0);
        drained(r);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) tw[k] = 32'h00A5_0F3C ^ (32'h0013_5791 * (k + 1));
        repeat (4) @(negedge clk);
        // R10: reset state
        checks++;
        if (valid_o !== 1'b0 || sample_o !== 24'h0) begin
            errors++;
            $display("FAIL R10: valid=%b data=%h in reset, expected 0 and 000000", valid_o, sample_o);
        end
        // R10: data ones with a constant word clock produce nothing
        setup(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        for (int i = 0; i < 30; i++) bit_out(1'b1, 1'b1);
        drained("R10");
        // R1: I2S 24-bit
        setup(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
        run_2ch(32, 24, 32'h008A_BCDE, 32'h0012_3456, "R1");
        // R2: left-justified 24-bit
        setup(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R2");
        run_2ch(32, 24, 32'h00F0_0F5A, 32'h0076_5432, "R2");
        // R3: short word padded, long word truncated
        setup(2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
        run_2ch(20, 16, 32'h0000_BEEF, 32'h0000_1234, "R3");
        setup(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3");
        run_2ch(40, 32, 32'hDEAD_BEEF, 32'h8765_4321, "R3");
        // R4: right-justified, 24-bit and 16-bit
        setup(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
        run_2ch(32, 24, 32'h00C3_3C99, 32'h0001_0203, "R4");
        setup(2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
        run_2ch(32, 16, 32'h0000_A55A, 32'h0000_7FFE, "R4");
        // R5: TDM clock-style word clock, 8 slots
        setup(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        run_tdm(24, "R5");
        // R6: TDM pulse word clock, 20-bit words
        setup(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R6");
        run_tdm(20, "R6");
        // R7: 4-slot configuration over an 8-slot frame
        setup(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        run_tdm(24, "R7");
        // R8: inverted word clock with I2S
        setup(2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
        run_2ch(32, 24, 32'h0055_AA11, 32'h00EE_2277, "R8");
        // R9: inverted bit clock with left-justified
        setup(2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
        run_2ch(32, 24, 32'h0081_8181, 32'h007E_7E7E, "R9");
        // R11: strobe width
        checks++;
        if (b2b != 0) begin
            errors++;
            $display("FAIL R11: %0d back-to-back valid cycles, expected 0", b2b);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL %s: watchdog expired, expected run to complete", cur_req);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule